// File: doc/BRIEF.md
# HDLC Receive Deframer

This block sits behind the line decoder and clock recovery of a synchronous serial receiver. It takes one recovered bit for each cycle in which `bit_vld` is high. It hunts for the opening flag and deletes the zeros that the transmitter inserted. It packs the remaining bits into bytes, least significant bit first, and checks the 16-bit frame check sequence. The check bytes are not passed on. Each payload byte is offered for one cycle on `out_vld`. The last payload byte of a frame carries the end marker and the frame's status bits.

The block also reports two line conditions. A one-cycle strobe marks every recognised flag. A level shows a line that has been held at one for a long time. A discontinue input lets the surrounding logic give up on the frame in progress: the block then stays silent until the next flag. The consumer does not stall the block. It reports its readiness on `out_ready`, and a byte that finds it not ready is dropped and recorded as an overrun.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 01111110 is a flag. It produces a one-cycle `flag_seen` pulse. Two flags in a row produce no output beat.
- R2: A 0 that follows five consecutive 1s is removed. The remaining bits are packed least significant bit first and delivered in order on `out_vld`/`out_data`. Only cycles with `bit_vld` high carry bits.
- R3: The two bytes just before the closing flag are the check sequence and never appear on the output. The last payload byte is the only beat of a frame with `out_eof` high.
- R4: The check runs a CRC-16 register over the payload and the check sequence. The register starts at 0xFFFF, shifts LSB first with the reflected polynomial 0x8408, and a good frame leaves it at 0xF0B8. Any other value sets `out_crc_err` on the end beat. The check sequence is the complement of the payload CRC, sent low byte first.
- R5: If `crc_bypass` is high when the closing flag completes, `out_crc_err` stays low.
- R6: If the bit count between the flags is not a multiple of 8, `out_nonoctet` is set on the end beat.
- R7: Seven consecutive 1s inside a frame end it with a single beat that has `out_eof` and `out_abort` high, data 0x00, CRC and alignment status low. The block then waits for a flag.
- R8: `line_idle` is high once the 15 most recent bits were all 1s. It is still low after 14 of them.
- R9: A cycle with `discontinue` high drops the frame in progress. No beat appears for that frame, and the next flagged frame is received normally.
- R10: A payload byte completed while `out_ready` is low is not presented. The frame's end beat is always presented, and in that case it carries `out_overrun` high.
- R11: A frame with fewer than three whole bytes between its flags produces no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` holds a line bit this cycle |
| bit_in | input | 1 | Recovered line bit |
| crc_bypass | input | 1 | Suppress the CRC error status |
| discontinue | input | 1 | Drop the frame in progress |
| out_ready | input | 1 | Consumer can take a byte this cycle |
| out_vld | output | 1 | Byte beat strobe |
| out_data | output | 8 | Payload byte |
| out_eof | output | 1 | Last byte of frame, status valid |
| out_crc_err | output | 1 | Check sequence failed |
| out_nonoctet | output | 1 | Frame not a whole number of bytes |
| out_abort | output | 1 | Frame ended by an abort run |
| out_overrun | output | 1 | A byte of this frame was dropped |
| flag_seen | output | 1 | Flag recognised (pulse) |
| line_idle | output | 1 | 15 or more consecutive 1s received |

## Verification
The assertions assume that a flag never follows another within fewer than eight strobed bits. They also assume that `crc_bypass` and `out_ready` are ordinary synchronous levels, so their value one cycle back is the value the framer acted on. The stimulus sends every flag as a full eight-bit pattern and stuffs payload bits by a counter of its own. It changes the two levels only on the falling clock edge, between frames or for whole frames. The sweeps vary the payload length, pick byte values that force stuffing and look like flags, and insert gaps in the bit strobe.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int          OCTET      = 8;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_RESID  = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  // one LSB-first step of the reflected CRC-16 register
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_rx_linebits.sv
module hdlc_rx_linebits #(
  parameter int FLAG_RUN = 6,
  parameter int IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_data,
  output logic data_bit,
  output logic flag_seen,
  output logic line_idle
);
  localparam int CNT_W  = $clog2(IDLE_RUN + 1);
  localparam int DL_LEN = FLAG_RUN + 1;
  localparam int FILL_W = $clog2(DL_LEN + 1);
  localparam logic [CNT_W-1:0]  FLAG_CNT  = CNT_W'(FLAG_RUN);
  localparam logic [CNT_W-1:0]  STUFF_CNT = CNT_W'(FLAG_RUN - 1);
  localparam logic [CNT_W-1:0]  IDLE_CNT  = CNT_W'(IDLE_RUN);
  localparam logic [FILL_W-1:0] FULL      = FILL_W'(DL_LEN);

  logic [CNT_W-1:0]  ones;
  logic [DL_LEN-1:0] dline;
  logic [FILL_W-1:0] fill;
  logic              push;

  // bits wait in a delay line so the flag's own bits can be discarded
  assign ev_flag  = bit_vld && !bit_in && (ones == FLAG_CNT);
  assign ev_abort = bit_vld &&  bit_in && (ones == FLAG_CNT);
  assign push     = bit_vld && (bit_in ? (ones < FLAG_CNT) : (ones < STUFF_CNT));
  assign ev_data  = push && (fill == FULL);
  assign data_bit = dline[DL_LEN-1];
  assign line_idle = (ones == IDLE_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones      <= '0;
      dline     <= '0;
      fill      <= '0;
      flag_seen <= 1'b0;
    end else begin
      flag_seen <= ev_flag;
      if (bit_vld) begin
        if (bit_in) ones <= (ones == IDLE_CNT) ? ones : ones + 1'b1;
        else        ones <= '0;
      end
      if (ev_flag || ev_abort) begin
        fill <= '0;
      end else if (push) begin
        dline <= {dline[DL_LEN-2:0], bit_in};
        if (fill != FULL) fill <= fill + 1'b1;
      end
    end
  end

  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |=> !flag_seen); // R1
  AST_IDLE_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(bit_vld && bit_in)); // R8
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_flag,
  input  logic             ev_abort,
  input  logic             ev_data,
  input  logic             data_bit,
  input  logic             crc_bypass,
  input  logic             discontinue,
  input  logic             out_ready,
  output logic             out_vld,
  output logic [OCTET-1:0] out_data,
  output logic             out_eof,
  output logic             out_crc_err,
  output logic             out_nonoctet,
  output logic             out_abort,
  output logic             out_overrun
);
  localparam int HOLD_N = FCS_BYTES + 1;
  localparam int NB_W   = $clog2(HOLD_N + 1);
  localparam int BC_W   = $clog2(OCTET);
  localparam logic [NB_W-1:0] HOLD_FULL = NB_W'(HOLD_N);
  localparam logic [BC_W-1:0] LAST_BIT  = BC_W'(OCTET - 1);

  logic             in_frame;
  logic [BC_W-1:0]  bitcnt;
  logic [NB_W-1:0]  nbytes;
  logic [OCTET-1:0] shreg;
  logic [OCTET-1:0] hold [HOLD_N];
  logic [15:0]      crc;
  logic             ovr;
  logic [OCTET-1:0] sh_next;
  logic             byte_done;

  assign sh_next   = {data_bit, shreg[OCTET-1:1]};
  assign byte_done = ev_data && in_frame && (bitcnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0; bitcnt <= '0; nbytes <= '0; shreg <= '0;
      crc <= CRC_SEED; ovr <= 1'b0;
      for (int k = 0; k < HOLD_N; k++) hold[k] <= '0;
      out_vld <= 1'b0; out_data <= '0; out_eof <= 1'b0; out_crc_err <= 1'b0;
      out_nonoctet <= 1'b0; out_abort <= 1'b0; out_overrun <= 1'b0;
    end else begin
      out_vld <= 1'b0; out_eof <= 1'b0; out_crc_err <= 1'b0;
      out_nonoctet <= 1'b0; out_abort <= 1'b0; out_overrun <= 1'b0;
      if (discontinue) begin
        in_frame <= 1'b0;
      end else if (ev_flag) begin
        if (in_frame && nbytes == HOLD_FULL) begin
          out_vld      <= 1'b1;
          out_eof      <= 1'b1;
          out_data     <= hold[HOLD_N-1];
          out_crc_err  <= !crc_bypass && (crc != CRC_RESID);
          out_nonoctet <= (bitcnt != '0);
          out_overrun  <= ovr;
        end
        in_frame <= 1'b1; bitcnt <= '0; nbytes <= '0;
        crc <= CRC_SEED; ovr <= 1'b0;
      end else if (ev_abort) begin
        if (in_frame && (nbytes != '0 || bitcnt != '0)) begin
          out_vld   <= 1'b1;
          out_eof   <= 1'b1;
          out_abort <= 1'b1;
          out_data  <= '0;
        end
        in_frame <= 1'b0;
      end else if (ev_data && in_frame) begin
        shreg  <= sh_next;
        crc    <= crc_step(crc, data_bit);
        bitcnt <= bitcnt + 1'b1;
        if (byte_done) begin
          hold[0] <= sh_next;
          for (int k = 1; k < HOLD_N; k++) hold[k] <= hold[k-1];
          if (nbytes == HOLD_FULL) begin
            if (out_ready) begin
              out_vld  <= 1'b1;
              out_data <= hold[HOLD_N-1];
            end else begin
              ovr <= 1'b1;
            end
          end else begin
            nbytes <= nbytes + 1'b1;
          end
        end
      end
    end
  end

  AST_EOF_AT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && !out_abort) |-> $past(ev_flag)); // R3
  AST_CRC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_crc_err |-> !$past(crc_bypass)); // R5
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_eof && !out_crc_err && !out_nonoctet)); // R7
  AST_DISC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(discontinue) |-> !out_vld); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_eof) |-> $past(out_ready)); // R10
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int FLAG_RUN  = 6,
  parameter int IDLE_RUN  = 15,
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       crc_bypass,
  input  logic       discontinue,
  input  logic       out_ready,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic       out_eof,
  output logic       out_crc_err,
  output logic       out_nonoctet,
  output logic       out_abort,
  output logic       out_overrun,
  output logic       flag_seen,
  output logic       line_idle
);
  logic ev_flag, ev_abort, ev_data, data_bit;

  hdlc_rx_linebits #(.FLAG_RUN(FLAG_RUN), .IDLE_RUN(IDLE_RUN)) u_bits (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_data(ev_data),
    .data_bit(data_bit), .flag_seen(flag_seen), .line_idle(line_idle)
  );

  hdlc_rx_framer #(.FCS_BYTES(FCS_BYTES)) u_frm (
    .clk(clk), .rst_n(rst_n), .ev_flag(ev_flag), .ev_abort(ev_abort),
    .ev_data(ev_data), .data_bit(data_bit), .crc_bypass(crc_bypass),
    .discontinue(discontinue), .out_ready(out_ready),
    .out_vld(out_vld), .out_data(out_data), .out_eof(out_eof),
    .out_crc_err(out_crc_err), .out_nonoctet(out_nonoctet),
    .out_abort(out_abort), .out_overrun(out_overrun)
  );
endmodule

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_in = 0, crc_bypass = 0, discontinue = 0, out_ready = 1;
  logic out_vld, out_eof, out_crc_err, out_nonoctet, out_abort, out_overrun;
  logic flag_seen, line_idle;
  logic [7:0] out_data;

  int checks = 0, errors = 0, bn = 0, flags = 0, tx_ones = 0;
  bit done = 0, gap = 0;
  logic [12:0] bq [64];   // {ovr,abort,nono,crc,eof,data}
  logic [7:0]  pl [16];

  always #4 clk = ~clk;   // 125 MHz

  hdlc_rx_deframer uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .crc_bypass(crc_bypass), .discontinue(discontinue), .out_ready(out_ready),
    .out_vld(out_vld), .out_data(out_data), .out_eof(out_eof),
    .out_crc_err(out_crc_err), .out_nonoctet(out_nonoctet),
    .out_abort(out_abort), .out_overrun(out_overrun),
    .flag_seen(flag_seen), .line_idle(line_idle)
  );

  always @(negedge clk) if (rst_n) begin
    if (flag_seen) flags++;
    if (out_vld && bn < 64) begin
      bq[bn] = {out_overrun, out_abort, out_nonoctet, out_crc_err, out_eof, out_data};
      bn++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic send_raw(input logic b);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic send_flag();
    send_raw(0);
    for (int i = 0; i < 6; i++) send_raw(1);
    send_raw(0);
    tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_raw(v[i]);
      tx_ones = v[i] ? tx_ones + 1 : 0;
      if (tx_ones == 5) begin send_raw(0); tx_ones = 0; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pl[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] pat(input int p, input int n, input int i);
    case (p)
      0: return 8'(i * 29 + n * 7 + 1);
      1: return 8'hFF;
      default: return (i % 2) ? 8'h7E : 8'h3F;
    endcase
  endfunction

  // frame: opening flag, n payload bytes, FCS, extra bits, closing flag
  task automatic send_frame(input int n, input bit corrupt, input int extra);
    logic [15:0] f = fcs_of(n);
    bn = 0;
    send_flag();
    for (int i = 0; i < n; i++) send_byte((corrupt && i == 0) ? pl[i] ^ 8'h10 : pl[i]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    for (int i = 0; i < extra; i++) begin send_raw(i[0]); tx_ones = i[0] ? tx_ones + 1 : 0; end
    send_flag();
    idle(3);
  endtask

  task automatic expect_good(input int n, input string tag);
    bit ok = (bn == n);
    chk(ok, {tag, " beat count"}, bn, n);
    ok = 1;
    for (int i = 0; i < n && i < bn; i++)
      if (bq[i] != {4'b0000, (i == n - 1), pl[i]}) ok = 0;
    chk(ok, {tag, " beat contents"}, (bn > 0) ? int'(bq[bn-1]) : 0, {5'b00001, pl[n-1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    idle(3);
    chk(!out_vld && !flag_seen && !line_idle, "reset state", {out_vld, flag_seen, line_idle}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 sweep: lengths, payload patterns, strobe gaps
    for (int p = 0; p < 3; p++)
      for (int n = 1; n <= 8; n++) begin
        gap = n[0];
        for (int i = 0; i < n; i++) pl[i] = pat(p, n, i);
        send_frame(n, 0, 0);
        expect_good(n, "R2 R3 R4 good frame");
      end
    gap = 0;

    // R1 flag pulses, back-to-back flags give nothing
    f0 = flags; bn = 0;
    send_flag(); send_flag(); send_flag(); idle(3);
    chk(flags - f0 == 3, "R1 flag pulse count", flags - f0, 3);
    chk(bn == 0, "R1 no beat from back-to-back flags", bn, 0);

    // R4 corrupted payload
    for (int i = 0; i < 4; i++) pl[i] = 8'(i + 8'hA0);
    send_frame(4, 1, 0);
    chk(bn == 4 && bq[3][9] && bq[3][8], "R4 crc error on end beat", bn > 0 ? int'(bq[bn-1]) : 0, 'h300);

    // R5 bypass
    crc_bypass = 1'b1;
    send_frame(4, 1, 0);
    chk(bn == 4 && !bq[3][9] && bq[3][8], "R5 bypass clears crc error", bn > 0 ? int'(bq[bn-1]) : 0, 'h100);
    crc_bypass = 1'b0;

    // R6 three extra bits before the closing flag
    send_frame(3, 0, 3);
    chk(bn == 3 && bq[2][10] && bq[2][8] && bq[2][7:0] == pl[2], "R6 non-octet end beat",
        bn > 0 ? int'(bq[bn-1]) : 0, {3'b001, 2'b01, pl[2]});

    // R7 abort: 32 zero bits then seven ones
    bn = 0;
    send_flag();
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    for (int i = 0; i < 7; i++) send_raw(1);
    send_raw(0); idle(3);
    chk(bn == 1 && bq[0] == 13'h0900, "R7 abort beat", bn > 0 ? int'(bq[0]) : 0, 'h900);
    for (int i = 0; i < 2; i++) pl[i] = 8'(i + 8'h55);
    send_frame(2, 0, 0);
    expect_good(2, "R7 receive after abort");

    // R8 idle run
    for (int i = 0; i < 14; i++) send_raw(1);
    chk(!line_idle, "R8 idle low after 14 ones", line_idle, 0);
    send_raw(1);
    chk(line_idle, "R8 idle high after 15 ones", line_idle, 1);
    send_raw(0);
    chk(!line_idle, "R8 idle cleared by zero", line_idle, 0);

    // R9 discontinue after two payload bytes
    for (int i = 0; i < 6; i++) pl[i] = 8'(i * 3 + 8'h11);
    bn = 0;
    send_flag();
    send_byte(pl[0]); send_byte(pl[1]);
    discontinue = 1'b1; @(negedge clk); discontinue = 1'b0;
    for (int i = 2; i < 6; i++) send_byte(pl[i]);
    send_byte(8'h12); send_byte(8'h34);
    send_flag(); idle(3);
    chk(bn == 0, "R9 dropped frame is silent", bn, 0);
    send_frame(6, 0, 0);
    expect_good(6, "R9 next frame received");

    // R10 overrun
    out_ready = 1'b0;
    send_frame(5, 0, 0);
    out_ready = 1'b1;
    chk(bn == 1 && bq[0] == {5'b10001, pl[4]}, "R10 only end beat with overrun",
        bn > 0 ? int'(bq[0]) : 0, {5'b10001, pl[4]});

    // R11 short frames
    bn = 0;
    send_flag(); send_byte(8'hC3); send_byte(8'h3C); send_flag(); idle(3);
    chk(bn == 0, "R11 two-byte frame discarded", bn, 0);
    bn = 0;
    send_flag(); send_byte(8'h5A); send_raw(1); send_raw(0); send_flag(); idle(3);
    chk(bn == 0, "R11 short non-octet frame discarded", bn, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule